// File: doc/BRIEF.md
# Snooping Write-Back Cache Line Coherence Controller

This block keeps the lines of a small direct-mapped, write-back cache coherent with the other caches on an atomic shared bus. It uses write-invalidate with three line states. An invalid line holds nothing. A shared line is a clean copy that may only be read. An exclusive line is the single dirty copy and may be written. Each line holds one tag and one data word. An address is split into a line index in its low bits and a tag in the rest.

A processor request reaches the controller on the CPU side. The controller answers a hit from the line. On a miss it issues a read-miss or write-miss command on the bus. When it replaces a dirty line it first writes that line back. A write to a clean line is always handled as a write miss, so other copies are invalidated before the line becomes writable. On the snoop side the controller watches the misses that other caches place on the bus. If the snooped block is in this cache and dirty, the controller supplies the data and tells memory to drop its own response. A snooped write miss removes any copy held here. Because the bus is atomic, a fill word for a read miss is presented in the same cycle as the request. All outputs are registered and appear one cycle after the request. An output's address or data field is zero whenever its valid flag is low.

Top module: `msi_snoop_cache`

## Requirements
- R1: After reset every line is invalid and every output is 0.
- R2: A processor read that misses (line invalid or tag differs) gives missValid=1 and missWrite=0 with missAddr equal to the request address. cpuRdata returns fillData and cpuHit=0, and the line becomes shared with the new tag and word.
- R3: A processor write to an invalid line gives missValid=1 and missWrite=1 with no write-back. The line becomes exclusive and holds cpuWdata.
- R4: A processor read to a shared line with a matching tag gives cpuHit=1 and returns the stored word, with no bus command.
- R5: A processor write to a shared line, with either a matching or a different tag, gives a write miss (missWrite=1) and cpuHit=0, with no write-back. The line becomes exclusive with the new tag and word.
- R6: A processor read to a shared line with a different tag gives a read miss and no write-back, and the line stays shared under the new tag.
- R7: A read or write to an exclusive line with a matching tag gives cpuHit=1 and no bus command. A write replaces the stored word.
- R8: A processor read to an exclusive line with a different tag gives wbValid=1, with wbAddr equal to {old tag, index} and wbData equal to the old word. In the same cycle it gives a read miss, and the line becomes shared.
- R9: A processor write to an exclusive line with a different tag writes the old line back as in R8 and gives a write miss. The line stays exclusive under the new tag.
- R10: A snooped write miss (snoopWrite=1) that matches a shared line makes it invalid without a flush.
- R11: A snooped read miss (snoopWrite=0) that matches an exclusive line gives snpFlush=1 and memAbort=1, with snpData equal to the stored word. The line becomes shared.
- R12: A snooped write miss that matches an exclusive line flushes and aborts as in R11, and the line becomes invalid.
- R13: A snoop to an invalid line or with a different tag gives no flush and no abort, and leaves the line unchanged.
- R14: When a snoop and a processor request arrive in the same cycle, the snoop takes effect first and the processor request sees the line state the snoop left.
- cpuRdata carries the line's word after the access (for writes, the written word), and 0 when no request was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Request address {tag, index} |
| cpuWdata | input | DATA_W | Write word |
| fillData | input | DATA_W | Bus response word for a read miss |
| snoopValid | input | 1 | Foreign miss seen on the bus |
| snoopWrite | input | 1 | 1 = foreign write miss, 0 = foreign read miss |
| snoopAddr | input | ADDR_W | Address of the foreign miss |
| cpuAck | output | 1 | Request of the previous cycle answered |
| cpuHit | output | 1 | That request needed no miss command |
| cpuRdata | output | DATA_W | Line word after the access |
| missValid | output | 1 | Miss command issued |
| missWrite | output | 1 | 1 = write miss, 0 = read miss |
| missAddr | output | ADDR_W | Miss address |
| wbValid | output | 1 | Victim write-back issued |
| wbAddr | output | ADDR_W | Victim address |
| wbData | output | DATA_W | Victim word |
| snpFlush | output | 1 | This cache supplies the snooped block |
| snpData | output | DATA_W | Supplied word |
| memAbort | output | 1 | Memory must drop its response |

## Verification
The interesting collision is a snoop and a processor access landing on the same line in the same cycle. The bench drives both together for three cases: a snooped read against a dirty line with a processor read hit, a snooped write against a shared line with a processor write, and a snooped write against a dirty line with a processor read. It also drives them together in a long mixed random run over a few lines and tags. Each outcome is judged against a behavioural model that applies the snoop before the processor access. The flush, the miss command and the hit flag must all agree with that ordering.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_EXC = 2'd2
  } lineState_e;

  typedef struct packed {
    logic       snpWr;
    lineState_e snpState;
    logic       cpuWr;
    lineState_e cpuState;
    logic       cpuTagWr;
    logic       cpuDataWr;
    logic       cpuUseFill;
  } lineStrobe_t;

endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strobe,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic [IDX_W-1:0]  snpIdx,
  output lineState_e        cpuLineState,
  output logic [TAG_W-1:0]  cpuLineTag,
  output logic [DATA_W-1:0] cpuLineData,
  output lineState_e        snpLineState,
  output logic [TAG_W-1:0]  snpLineTag,
  output logic [DATA_W-1:0] snpLineData
);

  lineState_e        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rstN) begin
        stateQ[i] <= LS_INV;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end else begin
        // the processor decision already accounts for a same-cycle snoop
        if (strobe.cpuWr && (cpuIdx == IDX_W'(i)))
          stateQ[i] <= strobe.cpuState;
        else if (strobe.snpWr && (snpIdx == IDX_W'(i)))
          stateQ[i] <= strobe.snpState;
        if (strobe.cpuTagWr && (cpuIdx == IDX_W'(i)))
          tagQ[i] <= cpuTag;
        if (strobe.cpuDataWr && (cpuIdx == IDX_W'(i)))
          dataQ[i] <= strobe.cpuUseFill ? fillData : cpuWdata;
      end
    end
  end

  assign cpuLineState = stateQ[cpuIdx];
  assign cpuLineTag   = tagQ[cpuIdx];
  assign cpuLineData  = dataQ[cpuIdx];
  assign snpLineState = stateQ[snpIdx];
  assign snpLineTag   = tagQ[snpIdx];
  assign snpLineData  = dataQ[snpIdx];

endmodule

// File: rtl/msi_ctrl.sv
`timescale 1ns/1ps
module msi_ctrl
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [TAG_W-1:0]  snpTag,
  input  lineState_e        cpuLineState,
  input  logic [TAG_W-1:0]  cpuLineTag,
  input  logic [DATA_W-1:0] cpuLineData,
  input  lineState_e        snpLineState,
  input  logic [TAG_W-1:0]  snpLineTag,
  input  logic [DATA_W-1:0] snpLineData,
  output lineStrobe_t       strobe,
  output logic              cpuAck,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              missValid,
  output logic              missWrite,
  output logic [ADDR_W-1:0] missAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData,
  output logic              memAbort
);

  // snoop side
  logic       snpMatch;
  logic       snpDirty;
  logic       snpChanges;
  lineState_e snpNext;

  always_comb begin
    snpMatch   = snoopValid && (snpLineState != LS_INV) && (snpLineTag == snpTag);
    snpDirty   = snpMatch && (snpLineState == LS_EXC);
    snpChanges = snpMatch && (snoopWrite || (snpLineState == LS_EXC));
    if (snoopWrite)                    snpNext = LS_INV;
    else if (snpLineState == LS_EXC)   snpNext = LS_SHD;
    else                               snpNext = snpLineState;
  end

  // processor side, on the state the snoop leaves behind
  lineState_e        effState;
  logic              tagEq;
  logic              readHit;
  logic              writeHit;
  logic              needMiss;
  logic              needWb;
  logic              hitOut;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    effState = (snpChanges && (snpIdx == cpuIdx)) ? snpNext : cpuLineState;
    tagEq    = (cpuLineTag == cpuTag);
    readHit  = (effState != LS_INV) && tagEq;
    writeHit = (effState == LS_EXC) && tagEq;
    hitOut   = cpuWrite ? writeHit : readHit;
    needMiss = !hitOut;
    needWb   = needMiss && (effState == LS_EXC);
    if (cpuWrite)     rdNext = cpuWdata;
    else if (readHit) rdNext = cpuLineData;
    else              rdNext = fillData;
  end

  always_comb begin
    strobe            = '0;
    strobe.snpWr      = snpChanges;
    strobe.snpState   = snpNext;
    strobe.cpuWr      = cpuValid && needMiss;
    strobe.cpuState   = cpuWrite ? LS_EXC : LS_SHD;
    strobe.cpuTagWr   = cpuValid && needMiss;
    strobe.cpuDataWr  = cpuValid && (needMiss || cpuWrite);
    strobe.cpuUseFill = !cpuWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuAck    <= 1'b0;
      cpuHit    <= 1'b0;
      cpuRdata  <= '0;
      missValid <= 1'b0;
      missWrite <= 1'b0;
      missAddr  <= '0;
      wbValid   <= 1'b0;
      wbAddr    <= '0;
      wbData    <= '0;
      snpFlush  <= 1'b0;
      snpData   <= '0;
      memAbort  <= 1'b0;
    end else begin
      cpuAck    <= cpuValid;
      cpuHit    <= cpuValid && hitOut;
      cpuRdata  <= cpuValid ? rdNext : '0;
      missValid <= cpuValid && needMiss;
      missWrite <= cpuValid && needMiss && cpuWrite;
      missAddr  <= (cpuValid && needMiss) ? {cpuTag, cpuIdx} : '0;
      wbValid   <= cpuValid && needWb;
      wbAddr    <= (cpuValid && needWb) ? {cpuLineTag, cpuIdx} : '0;
      wbData    <= (cpuValid && needWb) ? cpuLineData : '0;
      snpFlush  <= snpDirty;
      snpData   <= snpDirty ? snpLineData : '0;
      memAbort  <= snpDirty;
    end
  end

  // R4: a read hit stays off the bus
  a_r4_read_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !cpuWrite && (effState != LS_INV) && (cpuLineTag == cpuTag))
      |=> (!missValid && !wbValid));

  // R8: replacing a dirty line always writes it back alongside the miss
  a_r8_dirty_victim_flushed: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && (effState == LS_EXC) && (cpuLineTag != cpuTag))
      |=> (wbValid && missValid));

  // R6: a clean line is never written back
  a_r6_clean_victim_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && (effState == LS_SHD)) |=> !wbValid);

  // R13: a snoop with a foreign tag never flushes
  a_r13_foreign_snoop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (snoopValid && (snpLineTag != snpTag)) |=> !snpFlush);

  // R11: memory is only told to abort when this cache supplies the block
  a_r11_abort_only_on_flush: assert property (@(posedge clk) disable iff (!rstN)
    memAbort |-> snpFlush);

endmodule

// File: rtl/msi_snoop_cache.sv
`timescale 1ns/1ps
module msi_snoop_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] fillData,
  input  logic              snoopValid,
  input  logic              snoopWrite,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              cpuAck,
  output logic              cpuHit,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              missValid,
  output logic              missWrite,
  output logic [ADDR_W-1:0] missAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData,
  output logic              memAbort
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpuIdx;
  logic [TAG_W-1:0]  cpuTag;
  logic [IDX_W-1:0]  snpIdx;
  logic [TAG_W-1:0]  snpTag;
  lineStrobe_t       strobe;
  lineState_e        cpuLineState;
  logic [TAG_W-1:0]  cpuLineTag;
  logic [DATA_W-1:0] cpuLineData;
  lineState_e        snpLineState;
  logic [TAG_W-1:0]  snpLineTag;
  logic [DATA_W-1:0] snpLineData;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snoopAddr[IDX_W-1:0];
  assign snpTag = snoopAddr[ADDR_W-1:IDX_W];

  msi_line_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuIdx      (cpuIdx),
    .cpuTag      (cpuTag),
    .cpuWdata    (cpuWdata),
    .fillData    (fillData),
    .snpIdx      (snpIdx),
    .cpuLineState(cpuLineState),
    .cpuLineTag  (cpuLineTag),
    .cpuLineData (cpuLineData),
    .snpLineState(snpLineState),
    .snpLineTag  (snpLineTag),
    .snpLineData (snpLineData)
  );

  msi_ctrl #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuValid    (cpuValid),
    .cpuWrite    (cpuWrite),
    .cpuIdx      (cpuIdx),
    .cpuTag      (cpuTag),
    .cpuWdata    (cpuWdata),
    .fillData    (fillData),
    .snoopValid  (snoopValid),
    .snoopWrite  (snoopWrite),
    .snpIdx      (snpIdx),
    .snpTag      (snpTag),
    .cpuLineState(cpuLineState),
    .cpuLineTag  (cpuLineTag),
    .cpuLineData (cpuLineData),
    .snpLineState(snpLineState),
    .snpLineTag  (snpLineTag),
    .snpLineData (snpLineData),
    .strobe      (strobe),
    .cpuAck      (cpuAck),
    .cpuHit      (cpuHit),
    .cpuRdata    (cpuRdata),
    .missValid   (missValid),
    .missWrite   (missWrite),
    .missAddr    (missAddr),
    .wbValid     (wbValid),
    .wbAddr      (wbAddr),
    .wbData      (wbData),
    .snpFlush    (snpFlush),
    .snpData     (snpData),
    .memAbort    (memAbort)
  );

endmodule

// File: tb/msi_snoop_cache_test.sv
`timescale 1ns/1ps
module msi_snoop_cache_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cpuValid, cpuWrite, snoopValid, snoopWrite;
  logic [7:0] cpuAddr, cpuWdata, fillData, snoopAddr;
  logic       cpuAck, cpuHit, missValid, missWrite, wbValid, snpFlush, memAbort;
  logic [7:0] cpuRdata, missAddr, wbAddr, wbData, snpData;

  always #10 clk = ~clk;   // 50 MHz

  msi_snoop_cache uut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .fillData(fillData),
    .snoopValid(snoopValid), .snoopWrite(snoopWrite), .snoopAddr(snoopAddr),
    .cpuAck(cpuAck), .cpuHit(cpuHit), .cpuRdata(cpuRdata),
    .missValid(missValid), .missWrite(missWrite), .missAddr(missAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData),
    .snpFlush(snpFlush), .snpData(snpData), .memAbort(memAbort)
  );

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  int    mSt [4];   // 0 invalid, 1 shared, 2 exclusive
  int    mTag[4];
  int    mDat[4];
  logic [46:0] expVec;
  string expReq;

  function automatic logic [46:0] actual();
    return {cpuAck, cpuHit, cpuRdata, missValid, missWrite, missAddr,
            wbValid, wbAddr, wbData, snpFlush, snpData, memAbort};
  endfunction

  task automatic compare();
    vectors++;
    if (actual() !== expVec) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", expReq, actual(), expVec);
    end
  endtask

  task automatic step(string req, bit cv, bit cw, int ca, int cwd, int fd,
                      bit sv, bit sw, int sa);
    logic       eAck, eHit, eMv, eMw, eWv, eSf, eAb;
    logic [7:0] eRd, eMa, eWa, eWd, eSd;
    int         i, t;
    @(negedge clk);
    compare();
    cpuValid = cv; cpuWrite = cw; cpuAddr = 8'(ca); cpuWdata = 8'(cwd);
    fillData = 8'(fd); snoopValid = sv; snoopWrite = sw; snoopAddr = 8'(sa);
    {eAck, eHit, eMv, eMw, eWv, eSf, eAb} = '0;
    {eRd, eMa, eWa, eWd, eSd} = '0;
    if (sv) begin
      i = sa & 3; t = (sa >> 2) & 63;
      if (mSt[i] != 0 && mTag[i] == t) begin
        if (mSt[i] == 2) begin
          eSf = 1; eAb = 1; eSd = 8'(mDat[i]);
          mSt[i] = sw ? 0 : 1;
        end else if (sw) mSt[i] = 0;
      end
    end
    if (cv) begin
      i = ca & 3; t = (ca >> 2) & 63;
      eAck = 1;
      if (!cw) begin
        if (mSt[i] != 0 && mTag[i] == t) begin
          eHit = 1; eRd = 8'(mDat[i]);
        end else begin
          eMv = 1; eMa = 8'(ca);
          if (mSt[i] == 2) begin eWv = 1; eWa = 8'(mTag[i] * 4 + i); eWd = 8'(mDat[i]); end
          mSt[i] = 1; mTag[i] = t; mDat[i] = fd; eRd = 8'(fd);
        end
      end else begin
        if (mSt[i] == 2 && mTag[i] == t) begin
          eHit = 1;
        end else begin
          eMv = 1; eMw = 1; eMa = 8'(ca);
          if (mSt[i] == 2) begin eWv = 1; eWa = 8'(mTag[i] * 4 + i); eWd = 8'(mDat[i]); end
          mSt[i] = 2; mTag[i] = t;
        end
        mDat[i] = cwd; eRd = 8'(cwd);
      end
    end
    expVec = {eAck, eHit, eRd, eMv, eMw, eMa, eWv, eWa, eWd, eSf, eSd, eAb};
    expReq = req;
  endtask

  initial begin
    rstN = 1'b0;
    cpuValid = 0; cpuWrite = 0; cpuAddr = 0; cpuWdata = 0; fillData = 0;
    snoopValid = 0; snoopWrite = 0; snoopAddr = 0;
    for (int k = 0; k < 4; k++) begin mSt[k] = 0; mTag[k] = 0; mDat[k] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expVec = '0; expReq = "R1";
    // processor side
    step("R2",  1, 0, 'h04, 0,    'h33, 0, 0, 0);
    step("R4",  1, 0, 'h04, 0,    'h99, 0, 0, 0);
    step("R5",  1, 1, 'h04, 'h10, 0,    0, 0, 0);
    step("R7",  1, 0, 'h04, 0,    'h99, 0, 0, 0);
    step("R7",  1, 1, 'h04, 'h11, 0,    0, 0, 0);
    step("R8",  1, 0, 'h08, 0,    'h55, 0, 0, 0);
    step("R6",  1, 0, 'h0C, 0,    'h66, 0, 0, 0);
    step("R5",  1, 1, 'h10, 'h77, 0,    0, 0, 0);
    step("R9",  1, 1, 'h14, 'h78, 0,    0, 0, 0);
    // snoop side
    step("R11", 0, 0, 0,    0,    0,    1, 0, 'h14);
    step("R11", 1, 0, 'h14, 0,    'h99, 0, 0, 0);
    step("R10", 0, 0, 0,    0,    0,    1, 1, 'h14);
    step("R10", 1, 0, 'h14, 0,    'h44, 0, 0, 0);
    step("R3",  1, 1, 'h01, 'h10, 0,    0, 0, 0);
    step("R12", 0, 0, 0,    0,    0,    1, 1, 'h01);
    step("R12", 1, 0, 'h01, 0,    'h21, 0, 0, 0);
    step("R3",  1, 1, 'h02, 'h20, 0,    0, 0, 0);
    step("R13", 0, 0, 0,    0,    0,    1, 1, 'h06);
    step("R13", 0, 0, 0,    0,    0,    1, 0, 'h03);
    step("R13", 1, 0, 'h02, 0,    'h99, 0, 0, 0);
    // same-cycle snoop and processor access on one line
    step("R14", 1, 0, 'h02, 0,    'h99, 1, 0, 'h02);
    step("R14", 1, 1, 'h02, 'h2A, 0,    1, 1, 'h02);
    step("R14", 1, 0, 'h02, 0,    'h3B, 1, 1, 'h02);
    // another cache reads a freshly written block
    step("R11", 1, 1, 'h07, 'h0A, 0,    0, 0, 0);
    step("R11", 0, 0, 0,    0,    0,    1, 0, 'h07);
    step("R4",  1, 0, 'h07, 0,    'h99, 0, 0, 0);
    // mixed random traffic on a few tags
    begin
      int seed = 32'h1234_5678;
      for (int n = 0; n < 400; n++) begin
        seed = seed * 1103515245 + 12345;
        step("R14", seed[16], seed[17], (seed >> 18) & 31, (seed >> 8) & 255,
             (seed >> 3) & 255, seed[23], seed[24], (seed >> 25) & 31);
      end
    end
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule